// File: doc/BRIEF.md
# Transactional Cache Line State Tracker

This block holds the per-line transaction metadata of a small direct-mapped cache. Each set carries a valid flag, a stored tag, a transaction-touched flag (T) and an overflow flag (O). The block watches the cache's access and eviction events and the core's transaction begin, commit and abort controls. It tells the cache when an access lands on an overflowed set, which means main memory must be consulted. It flags an eviction that pushes a transactional line out of the cache. It also answers, in the same cycle, whether a remote coherence request hits a line the running transaction has touched.

An eviction does not abort the transaction. The evicted set is marked overflowed, so a transaction can grow past the cache's capacity. On commit, all T flags are cleared in one cycle. The overflowed sets are then handed out one per cycle, lowest set index first, on a valid/ready write-back stream. A busy output stays high until that stream has drained, and no new transaction may begin while it is high.

On the stream, `wb_valid` and `wb_idx` remain stable while `wb_ready` is low. A set is released only on a cycle where valid and ready are both high. Data storage and the coherence protocol are handled elsewhere.

Top module: `tx_line_tracker`

## Requirements
- R1: After reset, `tx_active`, `busy` and `wb_valid` are 0, and `acc_hit`, `mem_check`, `evict_ovf` and `conflict` are 0 for every input.
- R2: A rising edge with `tx_begin` high while idle and not busy sets `tx_active` from the next cycle. While `tx_active` is high, an access sets the T flag of set `acc_addr[IDX_W-1:0]` and stores tag `acc_addr[ADDR_W-1:IDX_W]`.
- R3: When `evict_valid` is high during an active transaction and the addressed set has T set, `evict_ovf` is 1 in that same cycle. The set's O flag is set, and the line becomes invalid with T cleared.
- R4: `mem_check` equals `acc_valid` ANDed with the O flag of the accessed set, in the same cycle.
- R5: `conflict` is 1 in the same cycle exactly when `snoop_valid` is high and the snooped set is valid, has T set and holds the snooped tag.
- R6: A commit (`tx_commit` while active) clears every T flag and drops `tx_active` on the next cycle.
- R7: After a commit with any O flag set, `busy` is 1 from the next cycle. `wb_valid` presents the overflowed sets on `wb_idx` in ascending index order, one per handshake, and holds stable while `wb_ready` is low. `busy` and `wb_valid` drop on the cycle after the last handshake. A commit with no O flag set never raises `busy`.
- R8: `tx_begin` has no effect while `busy` is high.
- R9: `tx_abort`, or `irq_evt` (interrupt or thread migration), during an active transaction ends it on the next cycle. Every line with T set is invalidated, and all T and O flags are cleared. Abort takes priority over commit in the same cycle.
- R10: Outside a transaction, accesses leave the T flags clear and evictions never raise `evict_ovf` or set an O flag. `irq_evt` has no effect.
- R11: `acc_hit` is 1 in the same cycle exactly when `acc_valid` is high and the addressed set is valid and holds the access tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Start a transaction |
| tx_commit | input | 1 | Commit the active transaction |
| tx_abort | input | 1 | Abort the active transaction |
| irq_evt | input | 1 | Interrupt or thread migration; aborts an active transaction |
| acc_valid | input | 1 | Local read or write access event |
| acc_addr | input | ADDR_W | Access line address {tag, index} |
| evict_valid | input | 1 | Eviction event |
| evict_idx | input | IDX_W | Set being evicted |
| snoop_valid | input | 1 | Remote coherence request present |
| snoop_addr | input | ADDR_W | Remote request line address {tag, index} |
| wb_ready | input | 1 | Write-back consumer accepts an entry |
| tx_active | output | 1 | Transaction in progress |
| busy | output | 1 | Commit write-back in progress |
| acc_hit | output | 1 | Access matches a valid line |
| mem_check | output | 1 | Access lands on an overflowed set |
| evict_ovf | output | 1 | Transactional line evicted; set now overflowed |
| conflict | output | 1 | Remote request hits a transaction-touched line |
| wb_valid | output | 1 | Write-back entry offered |
| wb_idx | output | IDX_W | Set index of the offered entry |

## Verification
The hardest case to reach is the write-back drain with an arbitrary overflow pattern under back-pressure. Getting there takes a transaction, touches to every set, evictions of exactly the chosen sets and then a commit. The bench sweeps all 256 overflow patterns of the eight-set default. For each pattern it evicts the chosen sets inside a transaction, commits, and drains with `wb_ready` gated on alternate cycles for even patterns. A new begin is attempted during the drain. Some patterns take an abort path instead, through either abort source, to show that the overflow marks vanish and the touched lines are gone.

// File: rtl/tlt_pkg.sv
package tlt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WB   = 2'd2
  } tlt_state_e;
endpackage

// File: rtl/tlt_ctrl.sv
module tlt_ctrl
  import tlt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_begin,
  input  logic tx_commit,
  input  logic tx_abort,
  input  logic irq_evt,
  input  logic ovf_any,
  input  logic wb_last,
  output logic tx_active,
  output logic busy,
  output logic do_commit,
  output logic do_abort,
  output logic trk_en
);
  tlt_state_e st_q, st_d;

  assign tx_active = (st_q == ST_TX);
  assign busy      = (st_q == ST_WB);
  assign do_abort  = tx_active & (tx_abort | irq_evt);
  assign do_commit = tx_active & tx_commit & ~do_abort;
  assign trk_en    = tx_active & ~do_abort & ~do_commit;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (tx_begin) st_d = ST_TX;
      ST_TX: begin
        if (do_abort)       st_d = ST_IDLE;
        else if (do_commit) st_d = ovf_any ? ST_WB : ST_IDLE;
      end
      ST_WB:   if (wb_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/tlt_line_array.sv
module tlt_line_array #(
  parameter int NUM_SETS = 8,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           trk_en,
  input  logic                           do_commit,
  input  logic                           do_abort,
  input  logic                           acc_valid,
  input  logic [IDX_W-1:0]               acc_idx,
  input  logic [TAG_W-1:0]               acc_tag,
  input  logic                           ev_valid,
  input  logic [IDX_W-1:0]               ev_idx,
  input  logic [NUM_SETS-1:0]            wb_clr,
  output logic [NUM_SETS-1:0]            vld_vec,
  output logic [NUM_SETS-1:0]            t_vec,
  output logic [NUM_SETS-1:0]            o_vec,
  output logic [NUM_SETS-1:0][TAG_W-1:0] tag_vec
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic acc_here, ev_here;
    assign acc_here = acc_valid && (acc_idx == IDX_W'(s));
    assign ev_here  = ev_valid  && (ev_idx  == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_vec[s] <= 1'b0;
        t_vec[s]   <= 1'b0;
        o_vec[s]   <= 1'b0;
        tag_vec[s] <= '0;
      end else if (do_abort) begin
        if (t_vec[s]) vld_vec[s] <= 1'b0;
        t_vec[s] <= 1'b0;
        o_vec[s] <= 1'b0;
      end else begin
        if (do_commit) t_vec[s] <= 1'b0;
        if (ev_here) begin
          vld_vec[s] <= 1'b0;
          t_vec[s]   <= 1'b0;
          if (t_vec[s] && trk_en) o_vec[s] <= 1'b1;
        end
        if (acc_here) begin
          vld_vec[s] <= 1'b1;
          tag_vec[s] <= acc_tag;
          if (trk_en) t_vec[s] <= 1'b1;
        end
        if (wb_clr[s]) o_vec[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlt_ovf_picker.sv
module tlt_ovf_picker #(
  parameter int NUM_SETS = 8,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic [NUM_SETS-1:0] o_vec,
  output logic                any,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_SETS-1:0] onehot,
  output logic                more
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = NUM_SETS - 1; i >= 0; i--) begin
      if (o_vec[i]) begin
        idx    = IDX_W'(i);
        onehot = NUM_SETS'(1) << i;
      end
    end
  end
  assign any  = |o_vec;
  assign more = |(o_vec & ~onehot);
endmodule

// File: rtl/tx_line_tracker.sv
module tx_line_tracker #(
  parameter int NUM_SETS = 8,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int ADDR_W  = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_commit,
  input  logic              tx_abort,
  input  logic              irq_evt,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              evict_valid,
  input  logic [IDX_W-1:0]  evict_idx,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              wb_ready,
  output logic              tx_active,
  output logic              busy,
  output logic              acc_hit,
  output logic              mem_check,
  output logic              evict_ovf,
  output logic              conflict,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx
);
  logic do_commit, do_abort, trk_en;
  logic ovf_any, ovf_more, wb_fire, wb_last;
  logic [NUM_SETS-1:0] vld_vec, t_vec, o_vec, pick_oh, wb_clr;
  logic [NUM_SETS-1:0][TAG_W-1:0] tag_vec;

  logic [IDX_W-1:0] a_idx, s_idx;
  logic [TAG_W-1:0] a_tag, s_tag;
  assign a_idx = acc_addr[IDX_W-1:0];
  assign a_tag = acc_addr[ADDR_W-1:IDX_W];
  assign s_idx = snoop_addr[IDX_W-1:0];
  assign s_tag = snoop_addr[ADDR_W-1:IDX_W];

  tlt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_begin  (tx_begin),
    .tx_commit (tx_commit),
    .tx_abort  (tx_abort),
    .irq_evt   (irq_evt),
    .ovf_any   (ovf_any),
    .wb_last   (wb_last),
    .tx_active (tx_active),
    .busy      (busy),
    .do_commit (do_commit),
    .do_abort  (do_abort),
    .trk_en    (trk_en)
  );

  tlt_line_array #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .trk_en    (trk_en),
    .do_commit (do_commit),
    .do_abort  (do_abort),
    .acc_valid (acc_valid),
    .acc_idx   (a_idx),
    .acc_tag   (a_tag),
    .ev_valid  (evict_valid),
    .ev_idx    (evict_idx),
    .wb_clr    (wb_clr),
    .vld_vec   (vld_vec),
    .t_vec     (t_vec),
    .o_vec     (o_vec),
    .tag_vec   (tag_vec)
  );

  tlt_ovf_picker #(.NUM_SETS(NUM_SETS)) u_pick (
    .o_vec  (o_vec),
    .any    (ovf_any),
    .idx    (wb_idx),
    .onehot (pick_oh),
    .more   (ovf_more)
  );

  assign wb_valid = busy & ovf_any;
  assign wb_fire  = wb_valid & wb_ready;
  assign wb_clr   = wb_fire ? pick_oh : '0;
  assign wb_last  = wb_fire & ~ovf_more;

  assign acc_hit   = acc_valid & vld_vec[a_idx] & (tag_vec[a_idx] == a_tag);
  assign mem_check = acc_valid & o_vec[a_idx];
  assign evict_ovf = evict_valid & trk_en & t_vec[evict_idx];
  assign conflict  = snoop_valid & vld_vec[s_idx] & t_vec[s_idx] &
                     (tag_vec[s_idx] == s_tag);
endmodule

// File: rtl/tlt_checker.sv
module tlt_checker #(
  parameter int NUM_SETS = 8,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_commit,
  input logic             tx_abort,
  input logic             irq_evt,
  input logic             tx_active,
  input logic             busy,
  input logic             evict_ovf,
  input logic             conflict,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [IDX_W-1:0] wb_idx
);
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_idx))); // R7
  AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy); // R7
  AST_NO_TX_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_active); // R8
  AST_EVICT_OVF_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ovf |-> tx_active); // R10
  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && tx_commit) |=> !tx_active); // R6
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && (tx_abort || irq_evt)) |=> (!tx_active && !busy)); // R9
  AST_NO_CONFLICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !conflict); // R10
endmodule

bind tx_line_tracker tlt_checker #(.NUM_SETS(NUM_SETS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_commit (tx_commit),
  .tx_abort  (tx_abort),
  .irq_evt   (irq_evt),
  .tx_active (tx_active),
  .busy      (busy),
  .evict_ovf (evict_ovf),
  .conflict  (conflict),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready),
  .wb_idx    (wb_idx)
);

// File: tb/tx_line_tracker_tb_top.sv
module tx_line_tracker_tb_top;
  localparam int NS = 8;
  localparam int TW = 4;
  localparam int IW = 3;
  localparam int AW = TW + IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_begin = 0, tx_commit = 0, tx_abort = 0, irq_evt = 0;
  logic acc_valid = 0, evict_valid = 0, snoop_valid = 0, wb_ready = 0;
  logic [AW-1:0] acc_addr = '0, snoop_addr = '0;
  logic [IW-1:0] evict_idx = '0;
  logic tx_active, busy, acc_hit, mem_check, evict_ovf, conflict, wb_valid;
  logic [IW-1:0] wb_idx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_line_tracker #(.NUM_SETS(NS), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort(tx_abort), .irq_evt(irq_evt), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .evict_valid(evict_valid), .evict_idx(evict_idx),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .wb_ready(wb_ready),
    .tx_active(tx_active), .busy(busy), .acc_hit(acc_hit),
    .mem_check(mem_check), .evict_ovf(evict_ovf), .conflict(conflict),
    .wb_valid(wb_valid), .wb_idx(wb_idx)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic idle_in();
    tx_begin = 0; tx_commit = 0; tx_abort = 0; irq_evt = 0;
    acc_valid = 0; evict_valid = 0; snoop_valid = 0; wb_ready = 0;
  endtask

  task automatic nxt();
    @(negedge clk);
    idle_in();
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return {TW'(tag), IW'(idx)};
  endfunction

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc_valid = 1; acc_addr = mk(3, 2); evict_valid = 1; evict_idx = 2;
    snoop_valid = 1; snoop_addr = mk(0, 0);
    #1;
    eq("R1 tx_active", tx_active, 0);
    eq("R1 busy", busy, 0);
    eq("R1 wb_valid", wb_valid, 0);
    eq("R1 acc_hit", acc_hit, 0);
    eq("R1 mem_check", mem_check, 0);
    eq("R1 evict_ovf", evict_ovf, 0);
    eq("R1 conflict", conflict, 0);
    nxt();
    irq_evt = 1;
    nxt();
    eq("R10 irq outside tx", tx_active, 0);

    for (int m = 0; m < 256; m++) begin
      int tag;
      int rem;
      bit abort_path;
      tag = m % 16;
      abort_path = ((m % 16) == 5);
      tx_begin = 1;
      nxt();
      eq("R2 tx_active after begin", tx_active, 1);
      for (int s = 0; s < NS; s++) begin
        acc_valid = 1; acc_addr = mk(tag, s);
        #1 eq("R4 mem_check clear set", mem_check, 0);
        nxt();
      end
      for (int s = 0; s < NS; s++) begin
        snoop_valid = 1; snoop_addr = mk(tag, s);
        #1 eq("R5 conflict on touched line", conflict, 1);
        snoop_addr = mk(tag ^ 1, s);
        #1 eq("R5 no conflict other tag", conflict, 0);
        acc_valid = 1; acc_addr = mk(tag, s);
        #1 eq("R11 hit on touched line", acc_hit, 1);
        nxt();
      end
      for (int s = 0; s < NS; s++) begin
        if (m[s]) begin
          evict_valid = 1; evict_idx = IW'(s);
          #1 eq("R3 evict_ovf", evict_ovf, 1);
          nxt();
          snoop_valid = 1; snoop_addr = mk(tag, s);
          acc_valid = 1; acc_addr = mk(tag, s);
          #1;
          eq("R3 evicted line invalid", acc_hit, 0);
          eq("R3 evicted line no conflict", conflict, 0);
          eq("R4 mem_check overflowed set", mem_check, 1);
          nxt();
        end else begin
          acc_valid = 1; acc_addr = mk(tag, s);
          #1 eq("R4 mem_check clean set", mem_check, 0);
          nxt();
        end
      end

      if (abort_path) begin
        if ((m % 32) == 5) irq_evt = 1; else tx_abort = 1;
        tx_commit = 1;
        nxt();
        eq("R9 tx_active after abort", tx_active, 0);
        eq("R9 busy after abort", busy, 0);
        for (int s = 0; s < NS; s++) begin
          acc_valid = 1; acc_addr = mk(tag, s);
          #1;
          eq("R9 line invalidated", acc_hit, 0);
          eq("R9 O cleared", mem_check, 0);
          nxt();
        end
      end else begin
        tx_commit = 1;
        nxt();
        eq("R6 tx_active after commit", tx_active, 0);
        eq("R7 busy after commit", busy, (m != 0) ? 1 : 0);
        snoop_valid = 1; snoop_addr = mk(tag, 0);
        #1 eq("R6 T cleared", conflict, 0);
        snoop_valid = 0;
        rem = m;
        for (int k = 0; k < 64 && rem != 0; k++) begin
          int low;
          if (k == 0) tx_begin = 1;
          wb_ready = (m % 2 == 1) || (k % 2 == 1);
          #1;
          eq("R7 wb_valid while draining", wb_valid, 1);
          eq("R7 busy while draining", busy, 1);
          eq("R8 begin refused", tx_active, 0);
          low = 0;
          for (int b = NS - 1; b >= 0; b--) if (rem[b]) low = b;
          if (wb_ready) begin
            eq("R7 wb_idx order", wb_idx, low);
            rem[low] = 1'b0;
          end else begin
            eq("R7 wb_idx offered", wb_idx, low);
          end
          nxt();
        end
        #1;
        eq("R7 busy after drain", busy, 0);
        eq("R7 wb_valid after drain", wb_valid, 0);
        eq("R8 no tx after refused begin", tx_active, 0);
        if (m % 8 == 3) begin
          acc_valid = 1; acc_addr = mk(tag, 1);
          nxt();
          snoop_valid = 1; snoop_addr = mk(tag, 1);
          evict_valid = 1; evict_idx = 1;
          #1;
          eq("R10 no T outside tx", conflict, 0);
          eq("R10 no evict_ovf outside tx", evict_ovf, 0);
          nxt();
          acc_valid = 1; acc_addr = mk(tag, 1);
          #1 eq("R10 no O outside tx", mem_check, 0);
          nxt();
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule